// File: doc/BRIEF.md
# Byte-Wide Instruction Fetch Unit

This block is the fetch stage of a single-cycle 32-bit processor. It keeps a program counter and a read-only instruction store that is organised in bytes. Every clock cycle it builds one 32-bit instruction from the four byte locations that start at the program counter and hands it to the decoder. On the rising clock edge it then moves the counter on by four, or to a target address when the control path asks for a branch or jump.

The store is filled from a fixed program built into the block. Locations past the populated range read as zero, and a zero word acts as a no-op. The block also exports the sequential successor address, PC+4, so that link-register writes and branch-offset arithmetic further down the pipeline can use it without an adder of their own.

Top module: `fetch_unit`

## Requirements
- R1: While `rstN` is low, `pcOut` is 0, and the first instruction presented after reset is released is the word at address 0 (0x2001001E).
- R2: On a rising clock edge with `rstN` high and `jumpSel` low, `pcOut` becomes its previous value plus 4.
- R3: On a rising clock edge with `rstN` high and `jumpSel` high, `pcOut` becomes `jumpTarget` with bits 1..0 forced to zero, so the counter is always word-aligned.
- R4: The instruction at word address A is assembled big-endian: the byte at A drives bits 31..24, A+1 drives 23..16, A+2 drives 15..8 and A+3 drives 7..0.
- R5: The store holds 64 bytes (16 words). Words 0 to 3 are 0x2001001E, 0xAC010000, 0x00221820 and 0x8C230004, and words 4 to 15 are zero.
- R6: When `pcOut` is 64 or higher, `instr` is 0x00000000.
- R7: `pcPlus4` always equals `pcOut` + 4, modulo 2^32.
- R8: `instr` depends combinationally on the current `pcOut`: it shows the new word in the same cycle that the counter changes, with no extra register stage.
- R9: `jumpSel` and `jumpTarget` are ignored while `rstN` is low, and the counter stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| jumpSel | input | 1 | High selects `jumpTarget` as the next counter value |
| jumpTarget | input | 32 | Branch or jump destination address |
| pcOut | output | 32 | Current program counter |
| pcPlus4 | output | 32 | Current program counter plus four |
| instr | output | 32 | Instruction word assembled at `pcOut` |

## Verification
A change to `jumpSel`, `jumpTarget` or `rstN` takes effect on `pcOut` at the next rising edge, one register away. `instr` and `pcPlus4` follow in that same cycle, because nothing but combinational logic sits between the counter and them. The bench drives inputs one nanosecond after a rising edge. It then waits for the next rising edge and samples one nanosecond after it, so each check compares all three outputs against values the bench has computed for the address that edge must have loaded. The jump sweep covers every word address inside and just beyond the store, along with misaligned targets.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Strobes from the control part to the datapath.
  typedef struct packed {
    logic takeJump;
    logic stepSeq;
  } pcCtl_t;

  // Built-in program, one 32-bit word per index; unused words read zero.
  function automatic logic [31:0] progWord(input int unsigned idx);
    logic [31:0] w;
    case (idx)
      0:       w = 32'h2001001E;
      1:       w = 32'hAC010000;
      2:       w = 32'h00221820;
      3:       w = 32'h8C230004;
      default: w = 32'h00000000;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic   jumpSel,
  output pcCtl_t ctl
);

  // Exactly one next-address source is chosen each cycle.
  always_comb begin
    ctl.takeJump = jumpSel;
    ctl.stepSeq  = ~jumpSel;
  end

endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
  import fetch_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int MEM_BYTES = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  pcCtl_t          ctl,
  input  logic [PC_W-1:0] jumpTarget,
  output logic [PC_W-1:0] pcOut,
  output logic [PC_W-1:0] pcPlus4,
  output logic [31:0]     instr
);

  localparam int IDX_W   = $clog2(MEM_BYTES);
  localparam int LANES   = 4;
  localparam int BYTE_W  = 8;

  logic [PC_W-1:0]   pcQ;
  logic [PC_W-1:0]   seqNext;
  logic [PC_W-1:0]   alignedTarget;
  logic [BYTE_W-1:0] romBytes [MEM_BYTES];

  assign seqNext       = pcQ + PC_W'(LANES);
  assign alignedTarget = {jumpTarget[PC_W-1:2], 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (ctl.takeJump) begin
      pcQ <= alignedTarget;
    end else if (ctl.stepSeq) begin
      pcQ <= seqNext;
    end
  end

  // Byte store filled from the built-in program, most significant byte first.
  always_comb begin
    for (int i = 0; i < MEM_BYTES; i++) begin
      romBytes[i] = progWord(i / LANES) >> (BYTE_W * (LANES - 1 - (i % LANES)));
    end
  end

  // One lane per byte of the instruction word; lane 0 is the lowest address.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PC_W-1:0] laneAddr;
    logic            inRange;
    assign laneAddr = pcQ + PC_W'(k);
    assign inRange  = laneAddr < PC_W'(MEM_BYTES);
    assign instr[BYTE_W*(LANES-k)-1 -: BYTE_W] =
      inRange ? romBytes[laneAddr[IDX_W-1:0]] : '0;
  end

  assign pcOut   = pcQ;
  assign pcPlus4 = seqNext;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepSeq |=> pcQ == $past(pcQ) + PC_W'(LANES));

  // R3
  jump_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeJump |=> pcQ == ($past(jumpTarget) & ~PC_W'(3)));

  // R3
  pc_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcQ[1:0] == 2'b00);

  // R6
  beyond_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcQ >= PC_W'(MEM_BYTES)) |-> instr == 32'h0);

  // R2
  ctl_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.takeJump, ctl.stepSeq}) == 1);

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int MEM_BYTES = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            jumpSel,
  input  logic [PC_W-1:0] jumpTarget,
  output logic [PC_W-1:0] pcOut,
  output logic [PC_W-1:0] pcPlus4,
  output logic [31:0]     instr
);

  pcCtl_t ctl;

  fetch_ctrl ctrl_i (
    .jumpSel (jumpSel),
    .ctl     (ctl)
  );

  fetch_datapath #(
    .PC_W      (PC_W),
    .MEM_BYTES (MEM_BYTES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .jumpTarget (jumpTarget),
    .pcOut      (pcOut),
    .pcPlus4    (pcPlus4),
    .instr      (instr)
  );

endmodule

// File: tb/fetch_unit_tb.sv
`timescale 1ns/1ps
module fetch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        jumpSel = 1'b0;
  logic [31:0] jumpTarget = '0;
  logic [31:0] pcOut, pcPlus4, instr;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  fetch_unit dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .jumpSel    (jumpSel),
    .jumpTarget (jumpTarget),
    .pcOut      (pcOut),
    .pcPlus4    (pcPlus4),
    .instr      (instr)
  );

  // Expected word at a byte address, per R5 and R6.
  function automatic logic [31:0] expWord(input logic [31:0] a);
    if (a >= 32'd64) return 32'h0;
    case (a >> 2)
      0: return 32'h2001001E;
      1: return 32'hAC010000;
      2: return 32'h00221820;
      3: return 32'h8C230004;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Full output check for an expected counter value (R4, R7, R8).
  task automatic checkAll(input string req, input logic [31:0] expPc);
    check(req, pcOut, expPc);
    check({req, "/R4/R8 instr"}, instr, expWord(expPc));
    check("R7 pcPlus4", pcPlus4, expPc + 32'd4);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [31:0] expPc;
    // R1: reset state
    tick();
    check("R1 reset pc", pcOut, 32'h0);
    // R9: jump request ignored while in reset
    jumpSel = 1'b1;
    jumpTarget = 32'd40;
    tick();
    check("R9 jump during reset", pcOut, 32'h0);
    tick();
    check("R9 jump during reset", pcOut, 32'h0);
    jumpSel = 1'b0;
    rstN = 1'b1;
    #0;
    check("R1 first word", instr, 32'h2001001E);
    // R2/R5/R6: sequential walk through and past the store
    expPc = 32'h0;
    for (int s = 0; s < 24; s++) begin
      tick();
      expPc = expPc + 32'd4;
      checkAll("R2 seq", expPc);
    end
    // R3/R4/R6: jump to every word address in and beyond the store, all offsets
    for (int w = 0; w < 26; w++) begin
      for (int off = 0; off < 4; off++) begin
        jumpSel = 1'b1;
        jumpTarget = 32'(w * 4 + off);
        tick();
        expPc = 32'(w * 4);
        checkAll("R3 jump", expPc);
        jumpSel = 1'b0;
        tick();
        expPc = expPc + 32'd4;
        checkAll("R2 after jump", expPc);
      end
    end
    // R7: wrap of pcPlus4 at the top of the address space
    jumpSel = 1'b1;
    jumpTarget = 32'hFFFF_FFFF;
    tick();
    checkAll("R3/R6 top", 32'hFFFF_FFFC);
    jumpSel = 1'b0;
    tick();
    checkAll("R2 wrap", 32'h0);
    // R1: reset mid-run returns to address 0
    rstN = 1'b0;
    #1;
    check("R1 async reset", pcOut, 32'h0);
    tick();
    rstN = 1'b1;
    tick();
    checkAll("R1 restart", 32'd4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule